// File: doc/BRIEF.md
# Capture/Compare Interval Timer

A W-bit up-counter (16 bits by default) that advances once for every clock in which an external prescaler raises its count-enable pulse. Two W-bit registers sit beside the counter. In compare use, register 0 is the match target and raises a match interrupt. In capture use, both registers latch the counter when their trigger input shows a valid edge. A mode input picks one of three behaviours: the counter runs freely and wraps, it restarts from zero when it reaches register 0, or it restarts from zero on a valid edge of trigger input A.

A small CPU port reads and writes the counter, the two registers and a flag word that holds the overflow flag. Each trigger input passes through a synchronizer, and its active edge can be set to rising, falling or both. The overflow flag is set whenever a count step leaves the all-ones value. This includes a restart-on-match from all-ones. A software clear that arrives before the counter has moved off zero after an overflow is dropped.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset the counter, both registers, the overflow flag and the match interrupt are all zero.
- R2: While `run_i` is high and `cnt_en_i` is high, the counter increases by one at each clock and wraps from all-ones to zero. It holds its value while `cnt_en_i` is low.
- R3: A count step taken while the counter is all-ones sets the overflow flag (bit 0 of the flag word at address 3). This covers both a free wrap and a restart-on-match with register 0 at all-ones. Writing the flag word with bit 0 set clears the flag.
- R4: After an overflow, a clear write is ignored until the counter has taken its next count step or been loaded. A new overflow always wins over a clear in the same cycle.
- R5: In mode 1 (restart on match) with `cap_mode_i` low, a count step taken while the counter equals register 0 loads zero. `match0_irq_o` is high for exactly the one cycle in which the counter first reads zero.
- R6: In mode 0 (free running) with `cap_mode_i` low, the same match raises `match0_irq_o` for one cycle without altering the count sequence.
- R7: Trigger edge selects are encoded 0 none, 1 rising, 2 falling, 3 both. An edge is acted on at the second clock after the clock that first samples the changed input level. Edges of a kind that is not selected have no effect.
- R8: In mode 2 (restart on trigger A), a valid edge of `ti0_i` loads zero into the counter. This load overrides a count step in the same cycle.
- R9: With `cap_mode_i` high, a valid edge on `ti0_i` copies the counter into register 1, and a valid edge on `ti1_i` copies it into register 0. In that cycle the capture overrides a CPU write to the same register.
- R10: `rdata_o` shows the word at `addr_i` (0 counter, 1 register 0, 2 register 1, 3 flag word). Reading the counter never changes register 1.
- R11: While `run_i` is low the counter is held at zero, and trigger edges cause no capture and no restart. Counting resumes from zero when `run_i` returns high.
- R12: A CPU write to address 0 loads the counter at the next clock, with priority over a trigger restart and over counting. A write to register 0 is used for match detection from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run (1) or stop (0) |
| mode_i | input | 2 | 0 free running, 1 restart on match, 2 restart on trigger A |
| cap_mode_i | input | 1 | 1: both registers act as capture registers |
| ti0_edge_i | input | 2 | Valid edge select for trigger A |
| ti1_edge_i | input | 2 | Valid edge select for trigger B |
| cnt_en_i | input | 1 | Count-enable pulse from the prescaler |
| ti0_i | input | 1 | Trigger A, asynchronous |
| ti1_i | input | 1 | Trigger B, asynchronous |
| wr_i | input | 1 | CPU write strobe |
| addr_i | input | 2 | CPU word address |
| wdata_i | input | W | CPU write data |
| rdata_o | output | W | CPU read data |
| match0_irq_o | output | 1 | One-cycle match pulse for register 0 |
| ovf_o | output | 1 | Overflow flag |

## Verification
The collisions that matter here are a trigger capture landing in the same cycle as a CPU write to the same register, and an overflow-flag clear landing while the counter still reads zero after a wrap. Directed sequences line up the input edge with the synchronizer delay, so that the capture and the write strobe meet at one clock. The clear write is likewise placed right after the wrap, and again after the next count step. A long stretch of random stimulus then mixes writes of near-all-ones values, restarts and stops. Every clock is compared against a behavioural model, which gives each collision a definite expected winner.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE      = 2'd0,
    MODE_CLR_MATCH = 2'd1,
    MODE_CLR_TI0   = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  typedef enum logic [1:0] {
    A_CNT  = 2'd0,
    A_CR0  = 2'd1,
    A_CR1  = 2'd2,
    A_FLAG = 2'd3
  } addr_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
  import tmr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sig_i,
  input  edge_e sel_i,
  input  logic  en_i,
  output logic  pulse_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] the one before it
  logic [STAGES:0] sh_q;
  logic cur, old, rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sig_i};
  end

  assign cur  = sh_q[STAGES-1];
  assign old  = sh_q[STAGES];
  assign rise = cur & ~old;
  assign fall = ~cur & old;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // stopped timer acknowledges no edge
  assign pulse_o = en_i & hit;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         cnt_en_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  input  logic         auto_clr_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         step_o,
  output logic         hit_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAX = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic eq;

  assign eq     = (cnt_q == cmp_i);
  assign step_o = run_i & cnt_en_i & ~ld_i & ~clr_i;
  assign hit_o  = step_o & eq;
  assign wrap_o = step_o & (cnt_q == MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (ld_i)      cnt_q <= ld_val_i;
    else if (clr_i)     cnt_q <= '0;
    else if (cnt_en_i)  cnt_q <= (auto_clr_i && eq) ? '0 : cnt_q + ONE;
  end
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        cap_i,
  input  logic [W-1:0]        cap_val_i,
  input  logic [N-1:0]        wr_i,
  input  logic [W-1:0]        wdata_i,
  output logic [N-1:0][W-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       r_q <= '0;
      else if (cap_i[i]) r_q <= cap_val_i;  // capture beats CPU write
      else if (wr_i[i])  r_q <= wdata_i;
    end
    assign q_o[i] = r_q;
  end
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [1:0]   mode_i,
  input  logic         cap_mode_i,
  input  logic [1:0]   ti0_edge_i,
  input  logic [1:0]   ti1_edge_i,
  input  logic         cnt_en_i,
  input  logic         ti0_i,
  input  logic         ti1_i,
  input  logic         wr_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         match0_irq_o,
  output logic         ovf_o
);
  mode_e mode;
  addr_e addr;
  logic ti0_ev, ti1_ev;
  logic wr_cnt, wr_cr0, wr_cr1, flag_clr;
  logic clr_ti0, auto_clr;
  logic [W-1:0] cnt_q;
  logic step, hit, wrap;
  logic [1:0][W-1:0] cr_q;
  logic ovf_q, ovf_guard_q, irq_q;

  assign mode = mode_e'(mode_i);
  assign addr = addr_e'(addr_i);

  tmr_edge_det #(.STAGES(SYNC_STAGES)) u_ti0 (
    .clk_i, .rst_ni, .sig_i(ti0_i), .sel_i(edge_e'(ti0_edge_i)),
    .en_i(run_i), .pulse_o(ti0_ev)
  );
  tmr_edge_det #(.STAGES(SYNC_STAGES)) u_ti1 (
    .clk_i, .rst_ni, .sig_i(ti1_i), .sel_i(edge_e'(ti1_edge_i)),
    .en_i(run_i), .pulse_o(ti1_ev)
  );

  assign wr_cnt   = wr_i && (addr == A_CNT);
  assign wr_cr0   = wr_i && (addr == A_CR0);
  assign wr_cr1   = wr_i && (addr == A_CR1);
  assign flag_clr = wr_i && (addr == A_FLAG) && wdata_i[0];
  assign clr_ti0  = (mode == MODE_CLR_TI0) && ti0_ev;
  assign auto_clr = !cap_mode_i && (mode == MODE_CLR_MATCH);

  tmr_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .run_i, .cnt_en_i,
    .ld_i(wr_cnt), .ld_val_i(wdata_i), .clr_i(clr_ti0),
    .auto_clr_i(auto_clr), .cmp_i(cr_q[0]),
    .cnt_o(cnt_q), .step_o(step), .hit_o(hit), .wrap_o(wrap)
  );

  // index 0: register 0 (trigger B), index 1: register 1 (trigger A)
  tmr_capcmp #(.W(W), .N(2)) u_cr (
    .clk_i, .rst_ni,
    .cap_i({cap_mode_i & ti0_ev, cap_mode_i & ti1_ev}),
    .cap_val_i(cnt_q),
    .wr_i({wr_cr1, wr_cr0}),
    .wdata_i,
    .q_o(cr_q)
  );

  // guard keeps the flag set while the counter still sits at zero after a wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q       <= 1'b0;
      ovf_guard_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (wrap)                         ovf_q <= 1'b1;
      else if (flag_clr && !ovf_guard_q) ovf_q <= 1'b0;
      ovf_guard_q <= wrap | (ovf_guard_q & run_i & ~step & ~wr_cnt);
      irq_q       <= hit & ~cap_mode_i;
    end
  end

  always_comb begin
    unique case (addr)
      A_CNT:   rdata_o = cnt_q;
      A_CR0:   rdata_o = cr_q[0];
      A_CR1:   rdata_o = cr_q[1];
      default: rdata_o = {{(W-1){1'b0}}, ovf_q};
    endcase
  end

  assign match0_irq_o = irq_q;
  assign ovf_o        = ovf_q;
endmodule

// File: rtl/cap_cmp_timer_chk.sv
module cap_cmp_timer_chk #(
  parameter int W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              cap_mode_i,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [W-1:0]      wdata_i,
  input logic              step,
  input logic              wrap,
  input logic [W-1:0]      cnt_q,
  input logic [1:0][W-1:0] cr_q,
  input logic              ti1_ev,
  input logic              ovf_guard_q,
  input logic              flag_clr,
  input logic              match0_irq_o,
  input logic              ovf_o
);
  assert_ovf_on_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (ovf_o && cnt_q == '0));

  assert_clear_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_guard_q && flag_clr) |=> ovf_o);

  assert_match_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !cap_mode_i && cnt_q == cr_q[0]) |=> match0_irq_o);

  assert_irq_after_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match0_irq_o |-> $past(step));

  assert_capture_r0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i && ti1_ev) |=> cr_q[0] == $past(cnt_q));

  assert_stopped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);

  assert_cnt_load_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wr_i && addr_i == 2'd0) |=> cnt_q == $past(wdata_i));
endmodule

bind cap_cmp_timer cap_cmp_timer_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .cap_mode_i(cap_mode_i),
  .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .step(step), .wrap(wrap), .cnt_q(cnt_q), .cr_q(cr_q), .ti1_ev(ti1_ev),
  .ovf_guard_q(ovf_guard_q), .flag_clr(flag_clr),
  .match0_irq_o(match0_irq_o), .ovf_o(ovf_o)
);

// File: tb/sim_cap_cmp_timer.sv
module sim_cap_cmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b1, cap = 1'b0, cnt_en = 1'b0, ti0 = 1'b0, ti1 = 1'b0, wr = 1'b0;
  logic [1:0] mode = 2'd0, e0_sel = 2'd2, e1_sel = 2'd3, addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq, ovf;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_cmp_timer #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .mode_i(mode), .cap_mode_i(cap),
    .ti0_edge_i(e0_sel), .ti1_edge_i(e1_sel), .cnt_en_i(cnt_en),
    .ti0_i(ti0), .ti1_i(ti1), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .match0_irq_o(irq), .ovf_o(ovf)
  );

  // behavioural reference
  logic [W-1:0] m_cnt, m_cr0, m_cr1, n_cnt;
  bit m_ovf, m_guard, m_irq;
  bit [2:0] m_h0, m_h1;
  bit ev0, ev1, st, wrc, clrq, ovs;

  function automatic bit edge_ok(bit cur, bit old, logic [1:0] sel);
    case (sel)
      2'd1: return cur && !old;
      2'd2: return !cur && old;
      2'd3: return cur != old;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cr0 = 0; m_cr1 = 0; m_ovf = 0; m_guard = 0; m_irq = 0;
      m_h0 = 0; m_h1 = 0;
    end else begin
      ev0 = run && edge_ok(m_h0[1], m_h0[2], e0_sel);
      ev1 = run && edge_ok(m_h1[1], m_h1[2], e1_sel);
      m_h0 = {m_h0[1:0], ti0};
      m_h1 = {m_h1[1:0], ti1};
      wrc  = wr && addr == 2'd0;
      st   = run && cnt_en && !wrc && !(mode == 2'd2 && ev0);
      ovs  = st && m_cnt == 16'hFFFF;
      clrq = wr && addr == 2'd3 && wdata[0];
      if (!run) n_cnt = 0;
      else if (wrc) n_cnt = wdata;
      else if (mode == 2'd2 && ev0) n_cnt = 0;
      else if (cnt_en) n_cnt = (!cap && mode == 2'd1 && m_cnt == m_cr0) ? 16'h0 : m_cnt + 16'h1;
      else n_cnt = m_cnt;
      m_irq = st && !cap && m_cnt == m_cr0;
      if (ovs) m_ovf = 1;
      else if (clrq && !m_guard) m_ovf = 0;
      m_guard = ovs || (m_guard && run && !st && !wrc);
      if (cap && ev1) m_cr0 = m_cnt; else if (wr && addr == 2'd1) m_cr0 = wdata;
      if (cap && ev0) m_cr1 = m_cnt; else if (wr && addr == 2'd2) m_cr1 = wdata;
      m_cnt = n_cnt;
    end
  end

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_cr0;
      2'd2: return m_cr1;
      default: return {15'h0, m_ovf};
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R10 rdata vs model", rdata, m_read(addr));
    chk("R3 ovf vs model", {15'h0, ovf}, {15'h0, m_ovf});
    chk("R5 irq vs model", {15'h0, irq}, {15'h0, m_irq});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulses(int n);
    cnt_en = 1;
    for (int i = 0; i < n; i++) tick();
    cnt_en = 0;
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [W-1:0] d);
    wr = 1; addr = a; wdata = d;
    tick();
    wr = 0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [W-1:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    rd_chk("R1 counter", 2'd0, 16'h0);
    rd_chk("R1 cr0", 2'd1, 16'h0);
    rd_chk("R1 cr1", 2'd2, 16'h0);
    chk("R1 ovf", {15'h0, ovf}, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    addr = 2'd0;
    pulses(5);   rd_chk("R2 count five", 2'd0, 16'd5);
    idle(3);     rd_chk("R2 hold", 2'd0, 16'd5);
    cpu_wr(2'd0, 16'hFFFE); rd_chk("R12 cnt load", 2'd0, 16'hFFFE);
    cpu_wr(2'd1, 16'h0010); rd_chk("R12 cr0 load", 2'd1, 16'h0010);
    addr = 2'd0;
    pulses(1);   chk("R3 no ovf yet", {15'h0, ovf}, 16'h0);
    pulses(1);   rd_chk("R2 wrap", 2'd0, 16'h0);
    chk("R3 ovf on wrap", {15'h0, ovf}, 16'h1);
    cpu_wr(2'd3, 16'h1); chk("R4 clear ignored", {15'h0, ovf}, 16'h1);
    pulses(1);
    cpu_wr(2'd3, 16'h1); chk("R3 clear works", {15'h0, ovf}, 16'h0);
    mode = 2'd1;
    cpu_wr(2'd1, 16'd3);
    addr = 2'd0;
    pulses(2);   rd_chk("R5 up to match", 2'd0, 16'd3);
    pulses(1);   chk("R5 irq", {15'h0, irq}, 16'h1);
    rd_chk("R5 restart", 2'd0, 16'h0);
    idle(1);     chk("R5 irq one cycle", {15'h0, irq}, 16'h0);
    cpu_wr(2'd1, 16'hFFFF);
    cpu_wr(2'd0, 16'hFFFE);
    pulses(2);   chk("R3 ovf on match clear", {15'h0, ovf}, 16'h1);
    rd_chk("R3 match clear zero", 2'd0, 16'h0);
    pulses(1);
    cpu_wr(2'd3, 16'h1);
    mode = 2'd0;
    cpu_wr(2'd1, 16'd5);
    cpu_wr(2'd0, 16'd4);
    pulses(1);   chk("R6 no irq", {15'h0, irq}, 16'h0);
    pulses(1);   chk("R6 irq free", {15'h0, irq}, 16'h1);
    rd_chk("R6 count continues", 2'd0, 16'd6);
    mode = 2'd2;
    ti0 = 1; idle(4); rd_chk("R7 rise ignored", 2'd0, 16'd6);
    ti0 = 0;
    tick(); rd_chk("R7 not yet", 2'd0, 16'd6);
    tick(); rd_chk("R7 not yet 2", 2'd0, 16'd6);
    tick(); rd_chk("R8 cleared by fall", 2'd0, 16'h0);
    mode = 2'd0; cap = 1; e0_sel = 2'd1;
    cpu_wr(2'd0, 16'h0100);
    ti1 = 1; tick(); tick();
    wr = 1; addr = 2'd1; wdata = 16'hBEEF;
    tick(); wr = 0;
    rd_chk("R9 capture beats write", 2'd1, 16'h0100);
    ti0 = 1; idle(3);
    rd_chk("R9 capture cr1", 2'd2, 16'h0100);
    addr = 2'd0;
    pulses(3);   rd_chk("R10 counter read", 2'd0, 16'h0103);
    rd_chk("R10 cr1 untouched", 2'd2, 16'h0100);
    run = 0; tick(); rd_chk("R11 stopped zero", 2'd0, 16'h0);
    ti0 = 0; ti1 = 0; idle(4);
    rd_chk("R11 no cap cr0", 2'd1, 16'h0100);
    rd_chk("R11 no cap cr1", 2'd2, 16'h0100);
    run = 1; addr = 2'd0;
    pulses(2);   rd_chk("R11 resume", 2'd0, 16'd2);
    for (int blk = 0; blk < 12; blk++) begin
      mode = 2'(blk % 3);
      cap = (blk % 4) == 3;
      e0_sel = 2'($urandom % 4);
      e1_sel = 2'($urandom % 4);
      for (int i = 0; i < 250; i++) begin
        run = ($urandom % 40) != 0;
        cnt_en = ($urandom % 3) != 0;
        if (($urandom % 7) == 0) ti0 = ~ti0;
        if (($urandom % 9) == 0) ti1 = ~ti1;
        wr = ($urandom % 6) == 0;
        addr = 2'($urandom % 4);
        wdata = (($urandom % 2) == 0) ? 16'(16'hFFF0 | ($urandom % 16)) : 16'($urandom % 32);
        tick();
      end
    end
    wr = 0; cnt_en = 0;
    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule